// File: doc/BRIEF.md
# Transaction Watchpoint Unit

This block sits beside a memory arbiter and watches the transactions it grants. It holds a set of independent watchpoints (four by default). Each one is set up with an inclusive address window, a mask of the operation kinds it cares about, and a mask of the clients it cares about. A transaction hits a watchpoint only when all three qualifiers agree. On a hit, the watchpoint records the details of the offending access. It keeps adding every client that hits to a sticky set, and it raises a status bit that can drive an interrupt.

Software reaches the block through a simple word-addressed register port. Writes take effect on the clock edge. Reads are returned combinationally from the current state. After servicing an interrupt, software clears the status bit through the interrupt-acknowledge register. It then re-arms the watchpoint's capture through that watchpoint's own acknowledge register. The block only observes: it never stalls or blocks the access.

Top module: `wp_watch_top`

## Requirements
- R1: After reset every configuration, capture, status and mask register reads 0 and `irq` is low; with a zero client mask no transaction can hit.
- R2: The address window is inclusive at both ends: a hit needs first ≤ address ≤ last.
- R3: A hit needs `obs_valid`, the operation enabled in the operation mask (bit 0 enables reads, `obs_write`=0; bit 1 enables writes, `obs_write`=1) and bit `obs_client` set in the client mask.
- R4: The first hit after arming captures the address into the hit-address register and builds the hit-info word: bit 0 is the write flag, bits 8 and up hold the client index, bits 16 and up hold the size.
- R5: While a watchpoint is captured, the hit address and hit info stay frozen. The hit-clients register, one bit per client index, collects the OR of every client that hits.
- R6: Any write to a watchpoint's acknowledge register clears its capture and its hit-clients set and re-arms it. The status bits are left untouched.
- R7: Every hit sets raw status bit i for watchpoint i. Writing 1 to bit i of the interrupt-acknowledge register clears that bit, and writing 0 leaves it alone.
- R8: Masked status reads raw status AND the interrupt mask, and `irq` is the OR of the masked status bits.
- R9: A hit in the same cycle as an interrupt acknowledge of its bit leaves the bit set.
- R10: A hit in the same cycle as a watchpoint acknowledge is captured as a fresh first hit, and the hit-clients set holds only its client.
- R11: Watchpoints act independently; one transaction may hit several at once, and each captures it.
- R12: Register word addresses: watchpoint u uses u*8 plus an offset. The offsets are 0 first address, 1 last address, 2 operation mask, 3 client mask, 4 hit clients, 5 hit address, 6 hit info and 7 acknowledge. The global registers are 32 interrupt mask, 33 raw status, 34 masked status and 35 interrupt acknowledge. Write-only and unused addresses read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| obs_valid | input | 1 | Observed transaction is valid this cycle |
| obs_addr | input | ADDR_W | Transaction address |
| obs_client | input | $clog2(NUM_CLI) | Index of the requesting client |
| obs_write | input | 1 | 1 for a write, 0 for a read |
| obs_size | input | SIZE_W | Transfer size |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | $clog2(NUM_WP)+4 | Register word address |
| reg_wdata | input | ADDR_W | Register write data |
| reg_rdata | output | ADDR_W | Register read data for `reg_addr` |
| irq | output | 1 | OR of masked status bits |

## Verification
Two collisions are provoked on purpose. In the first, a transaction that hits a watchpoint arrives in the same clock as an interrupt-acknowledge write to that watchpoint's bit. The raw status is then read back and must still show the bit. In the second, a hit coincides with a write to that watchpoint's acknowledge register. The hit address, the hit info and the hit-clients set are then read back and must describe only the new access, with no trace of the earlier capture.

// File: rtl/wp_pkg.sv
package wp_pkg;

    // per-watchpoint register offsets (low three address bits)
    localparam logic [2:0] OFS_FIRST  = 3'd0;
    localparam logic [2:0] OFS_LAST   = 3'd1;
    localparam logic [2:0] OFS_OPMASK = 3'd2;
    localparam logic [2:0] OFS_CLIMSK = 3'd3;
    localparam logic [2:0] OFS_HITCLI = 3'd4;
    localparam logic [2:0] OFS_HITADR = 3'd5;
    localparam logic [2:0] OFS_HITINF = 3'd6;
    localparam logic [2:0] OFS_ACK    = 3'd7;

    // global register offsets (low two bits inside the global page)
    localparam logic [1:0] GLB_MASK  = 2'd0;
    localparam logic [1:0] GLB_RAW   = 2'd1;
    localparam logic [1:0] GLB_MSKD  = 2'd2;
    localparam logic [1:0] GLB_IACK  = 2'd3;

    // hit-info word field positions
    localparam int INFO_CLI_LSB  = 8;
    localparam int INFO_SIZE_LSB = 16;

endpackage

// File: rtl/wp_match.sv
module wp_match #(
    parameter int ADDR_W  = 32,
    parameter int NUM_CLI = 16,
    localparam int CLI_W  = $clog2(NUM_CLI)
) (
    input  logic              obs_valid,
    input  logic [ADDR_W-1:0] obs_addr,
    input  logic [CLI_W-1:0]  obs_client,
    input  logic              obs_write,
    input  logic [ADDR_W-1:0] win_first,
    input  logic [ADDR_W-1:0] win_last,
    input  logic [1:0]        op_mask,
    input  logic [NUM_CLI-1:0] cli_mask,
    output logic              hit
);

    logic in_window;
    logic op_ok;
    logic cli_ok;

    always_comb begin
        in_window = (obs_addr >= win_first) && (obs_addr <= win_last);
        op_ok     = op_mask[obs_write];
        cli_ok    = cli_mask[obs_client];
        hit       = obs_valid && in_window && op_ok && cli_ok;
    end

endmodule

// File: rtl/wp_unit.sv
module wp_unit
    import wp_pkg::*;
#(
    parameter int ADDR_W  = 32,
    parameter int NUM_CLI = 16,
    parameter int SIZE_W  = 8,
    localparam int CLI_W  = $clog2(NUM_CLI)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_we,
    input  logic [2:0]        cfg_sel,
    input  logic [ADDR_W-1:0] cfg_wdata,
    input  logic              obs_valid,
    input  logic [ADDR_W-1:0] obs_addr,
    input  logic [CLI_W-1:0]  obs_client,
    input  logic              obs_write,
    input  logic [SIZE_W-1:0] obs_size,
    output logic              hit,
    output logic              captured,
    output logic [ADDR_W-1:0] cap_addr,
    output logic [ADDR_W-1:0] rdata
);

    typedef struct packed {
        logic [ADDR_W-1:0]  first;
        logic [ADDR_W-1:0]  last;
        logic [1:0]         opm;
        logic [NUM_CLI-1:0] clim;
        logic               capt;
        logic [NUM_CLI-1:0] hitcli;
        logic [ADDR_W-1:0]  caddr;
        logic               cwr;
        logic [CLI_W-1:0]   ccli;
        logic [SIZE_W-1:0]  csize;
    } unit_st_t;

    unit_st_t st_d, st_q;
    logic [NUM_CLI-1:0] cli_onehot;
    logic [ADDR_W-1:0]  info_word;

    wp_match #(.ADDR_W(ADDR_W), .NUM_CLI(NUM_CLI)) u_match (
        .obs_valid (obs_valid),
        .obs_addr  (obs_addr),
        .obs_client(obs_client),
        .obs_write (obs_write),
        .win_first (st_q.first),
        .win_last  (st_q.last),
        .op_mask   (st_q.opm),
        .cli_mask  (st_q.clim),
        .hit       (hit)
    );

    always_comb begin
        cli_onehot = NUM_CLI'(1) << obs_client;
        st_d = st_q;
        if (cfg_we) begin
            case (cfg_sel)
                OFS_FIRST:  st_d.first = cfg_wdata;
                OFS_LAST:   st_d.last  = cfg_wdata;
                OFS_OPMASK: st_d.opm   = cfg_wdata[1:0];
                OFS_CLIMSK: st_d.clim  = cfg_wdata[NUM_CLI-1:0];
                OFS_ACK: begin
                    st_d.capt   = 1'b0;
                    st_d.hitcli = '0;
                    st_d.caddr  = '0;
                    st_d.cwr    = 1'b0;
                    st_d.ccli   = '0;
                    st_d.csize  = '0;
                end
                default: ;
            endcase
        end
        // a hit is applied after any acknowledge, so it re-captures
        if (hit) begin
            st_d.hitcli = st_d.hitcli | cli_onehot;
            if (!st_d.capt) begin
                st_d.capt  = 1'b1;
                st_d.caddr = obs_addr;
                st_d.cwr   = obs_write;
                st_d.ccli  = obs_client;
                st_d.csize = obs_size;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        info_word = '0;
        info_word[0] = st_q.cwr;
        info_word[INFO_CLI_LSB +: CLI_W]   = st_q.ccli;
        info_word[INFO_SIZE_LSB +: SIZE_W] = st_q.csize;
        case (cfg_sel)
            OFS_FIRST:  rdata = st_q.first;
            OFS_LAST:   rdata = st_q.last;
            OFS_OPMASK: rdata = {{(ADDR_W-2){1'b0}}, st_q.opm};
            OFS_CLIMSK: rdata = {{(ADDR_W-NUM_CLI){1'b0}}, st_q.clim};
            OFS_HITCLI: rdata = {{(ADDR_W-NUM_CLI){1'b0}}, st_q.hitcli};
            OFS_HITADR: rdata = st_q.caddr;
            OFS_HITINF: rdata = info_word;
            default:    rdata = '0;
        endcase
        captured = st_q.capt;
        cap_addr = st_q.caddr;
    end

endmodule

// File: rtl/wp_intr.sv
module wp_intr #(
    parameter int NUM_WP = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_WP-1:0] hit_v,
    input  logic              mask_we,
    input  logic              iack_we,
    input  logic [NUM_WP-1:0] wbits,
    output logic [NUM_WP-1:0] raw_q,
    output logic [NUM_WP-1:0] mask_q,
    output logic              irq
);

    typedef struct packed {
        logic [NUM_WP-1:0] raw;
        logic [NUM_WP-1:0] mask;
    } intr_st_t;

    intr_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (mask_we) st_d.mask = wbits;
        if (iack_we) st_d.raw  = st_d.raw & ~wbits;
        st_d.raw = st_d.raw | hit_v;   // a new hit wins over a clear
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign raw_q  = st_q.raw;
    assign mask_q = st_q.mask;
    assign irq    = |(st_q.raw & st_q.mask);

endmodule

// File: rtl/wp_watch_top.sv
module wp_watch_top
    import wp_pkg::*;
#(
    parameter int NUM_WP  = 4,
    parameter int ADDR_W  = 32,
    parameter int NUM_CLI = 16,
    parameter int SIZE_W  = 8,
    localparam int CLI_W   = $clog2(NUM_CLI),
    localparam int UNIT_AW = $clog2(NUM_WP),
    localparam int REG_AW  = UNIT_AW + 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              obs_valid,
    input  logic [ADDR_W-1:0] obs_addr,
    input  logic [CLI_W-1:0]  obs_client,
    input  logic              obs_write,
    input  logic [SIZE_W-1:0] obs_size,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [ADDR_W-1:0] reg_wdata,
    output logic [ADDR_W-1:0] reg_rdata,
    output logic              irq
);

    logic                 glb_page;
    logic [UNIT_AW-1:0]   unit_idx;
    logic [2:0]           unit_ofs;
    logic                 glb_low_ok;
    logic                 mask_we;
    logic                 iack_we;
    logic [NUM_WP-1:0]    hit_v;
    logic [NUM_WP-1:0]    uack_v;
    logic [NUM_WP-1:0]    cap_v;
    logic [NUM_WP-1:0]    raw_q;
    logic [NUM_WP-1:0]    mask_q;
    logic [NUM_WP*ADDR_W-1:0] cap_addr_flat;
    logic [ADDR_W-1:0]    unit_rdata [NUM_WP];

    always_comb begin
        glb_page   = reg_addr[REG_AW-1];
        unit_idx   = reg_addr[REG_AW-2:3];
        unit_ofs   = reg_addr[2:0];
        glb_low_ok = (reg_addr[REG_AW-2:2] == '0);
        mask_we    = reg_we && glb_page && glb_low_ok && (reg_addr[1:0] == GLB_MASK);
        iack_we    = reg_we && glb_page && glb_low_ok && (reg_addr[1:0] == GLB_IACK);
    end

    for (genvar i = 0; i < NUM_WP; i++) begin : g_unit
        logic unit_we;
        assign unit_we   = reg_we && !glb_page && (unit_idx == UNIT_AW'(i));
        assign uack_v[i] = unit_we && (unit_ofs == OFS_ACK);

        wp_unit #(
            .ADDR_W (ADDR_W),
            .NUM_CLI(NUM_CLI),
            .SIZE_W (SIZE_W)
        ) u_unit (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (unit_we),
            .cfg_sel   (unit_ofs),
            .cfg_wdata (reg_wdata),
            .obs_valid (obs_valid),
            .obs_addr  (obs_addr),
            .obs_client(obs_client),
            .obs_write (obs_write),
            .obs_size  (obs_size),
            .hit       (hit_v[i]),
            .captured  (cap_v[i]),
            .cap_addr  (cap_addr_flat[i*ADDR_W +: ADDR_W]),
            .rdata     (unit_rdata[i])
        );
    end

    wp_intr #(.NUM_WP(NUM_WP)) u_intr (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_v  (hit_v),
        .mask_we(mask_we),
        .iack_we(iack_we),
        .wbits  (reg_wdata[NUM_WP-1:0]),
        .raw_q  (raw_q),
        .mask_q (mask_q),
        .irq    (irq)
    );

    always_comb begin
        reg_rdata = '0;
        if (!glb_page) begin
            reg_rdata = unit_rdata[unit_idx];
        end else if (glb_low_ok) begin
            case (reg_addr[1:0])
                GLB_MASK: reg_rdata = {{(ADDR_W-NUM_WP){1'b0}}, mask_q};
                GLB_RAW:  reg_rdata = {{(ADDR_W-NUM_WP){1'b0}}, raw_q};
                GLB_MSKD: reg_rdata = {{(ADDR_W-NUM_WP){1'b0}}, raw_q & mask_q};
                default:  reg_rdata = '0;
            endcase
        end
    end

endmodule

// File: rtl/wp_watch_chk.sv
module wp_watch_chk #(
    parameter int NUM_WP = 4,
    parameter int ADDR_W = 32
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic [NUM_WP-1:0]        hit_v,
    input logic [NUM_WP-1:0]        raw_q,
    input logic [NUM_WP-1:0]        mask_q,
    input logic                     irq,
    input logic                     mask_we,
    input logic                     iack_we,
    input logic [NUM_WP-1:0]        iack_bits,
    input logic [NUM_WP-1:0]        uack_v,
    input logic [NUM_WP-1:0]        cap_v,
    input logic [NUM_WP*ADDR_W-1:0] cap_addr_flat
);

    // R7 and R9: every hit leaves its status bit set, even against a clear
    a_r7_hit_sets_raw: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_v != '0) |=> ((raw_q & $past(hit_v)) == $past(hit_v)));

    // R7: acknowledged bits with no competing hit are cleared
    a_r7_iack_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (iack_we && ((iack_bits & hit_v) == '0)) |=> ((raw_q & $past(iack_bits)) == '0));

    // R8: no interrupt while every source is masked
    a_r8_irq_masked_off: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    // R8: a hit on an enabled source raises the interrupt next cycle
    a_r8_irq_follows_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (((hit_v & mask_q) != '0) && !mask_we) |=> irq);

    for (genvar i = 0; i < NUM_WP; i++) begin : g_unit_chk
        // R5: captured address held until acknowledged
        a_r5_capture_frozen: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_v[i] && !uack_v[i]) |=> $stable(cap_addr_flat[i*ADDR_W +: ADDR_W]));

        // R6: acknowledge without a hit re-arms the unit
        a_r6_ack_rearms: assert property (@(posedge clk) disable iff (!rst_n)
            (uack_v[i] && !hit_v[i]) |=> !cap_v[i]);

        // R4: a hit always leaves the unit captured
        a_r4_hit_captures: assert property (@(posedge clk) disable iff (!rst_n)
            hit_v[i] |=> cap_v[i]);
    end

endmodule

bind wp_watch_top wp_watch_chk #(.NUM_WP(NUM_WP), .ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .hit_v        (hit_v),
    .raw_q        (raw_q),
    .mask_q       (mask_q),
    .irq          (irq),
    .mask_we      (mask_we),
    .iack_we      (iack_we),
    .iack_bits    (reg_wdata[NUM_WP-1:0]),
    .uack_v       (uack_v),
    .cap_v        (cap_v),
    .cap_addr_flat(cap_addr_flat)
);

// File: tb/wp_watch_top_bench.sv
`timescale 1ns/1ps
module wp_watch_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        obs_valid = 1'b0;
    logic [31:0] obs_addr = '0;
    logic [3:0]  obs_client = '0;
    logic        obs_write = 1'b0;
    logic [7:0]  obs_size = '0;
    logic        reg_we = 1'b0;
    logic [5:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    always #2.5 clk = ~clk;

    wp_watch_top u_wp_watch_top (
        .clk(clk), .rst_n(rst_n),
        .obs_valid(obs_valid), .obs_addr(obs_addr), .obs_client(obs_client),
        .obs_write(obs_write), .obs_size(obs_size),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    typedef struct {
        string       tag;
        bit          is_irq;
        logic [5:0]  addr;
        logic [31:0] exp;
    } exp_item_t;

    exp_item_t exp_q[$];
    int n_vec  = 0;
    int n_miss = 0;
    bit done   = 0;

    // monitor: compares each expected item against the port values
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_item_t it;
                logic [31:0] act;
                it  = exp_q.pop_front();
                act = it.is_irq ? {31'b0, irq} : reg_rdata;
                n_vec++;
                if (act !== it.exp) begin
                    n_miss++;
                    $display("FAIL %s addr=%0d actual=0x%08h expected=0x%08h",
                             it.tag, it.addr, act, it.exp);
                end
            end
        end
    end

    function automatic logic [5:0] ua(input int u, input int ofs);
        return 6'(u * 8 + ofs);
    endfunction

    function automatic logic [5:0] ga(input int ofs);
        return 6'(32 + ofs);
    endfunction

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic set_obs(input logic [31:0] a, input logic [3:0] c,
                           input logic w, input logic [7:0] s);
        obs_valid = 1'b1; obs_addr = a; obs_client = c; obs_write = w; obs_size = s;
    endtask

    task automatic txn(input logic [31:0] a, input logic [3:0] c,
                       input logic w, input logic [7:0] s);
        @(negedge clk);
        set_obs(a, c, w, s);
        @(posedge clk); #1;
        obs_valid = 1'b0;
    endtask

    task automatic txn_wr(input logic [31:0] a, input logic [3:0] c,
                          input logic w, input logic [7:0] s,
                          input logic [5:0] ra, input logic [31:0] rd);
        @(negedge clk);
        set_obs(a, c, w, s);
        reg_we = 1'b1; reg_addr = ra; reg_wdata = rd;
        @(posedge clk); #1;
        obs_valid = 1'b0; reg_we = 1'b0;
    endtask

    task automatic chk(input logic [5:0] a, input logic [31:0] e, input string tag);
        exp_item_t it;
        @(negedge clk);
        reg_addr = a;
        it.tag = tag; it.is_irq = 1'b0; it.addr = a; it.exp = e;
        exp_q.push_back(it);
        @(posedge clk); #3;
    endtask

    task automatic chk_irq(input logic e, input string tag);
        exp_item_t it;
        @(negedge clk);
        it.tag = tag; it.is_irq = 1'b1; it.addr = '0; it.exp = {31'b0, e};
        exp_q.push_back(it);
        @(posedge clk); #3;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_miss++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        chk(ua(0, 0), 32'h0, "R1");
        chk(ua(2, 3), 32'h0, "R1");
        chk(ga(1), 32'h0, "R1");
        chk_irq(1'b0, "R1");
        txn(32'h0, 4'd0, 1'b0, 8'd1);          // zero client mask: no hit
        chk(ga(1), 32'h0, "R1");

        // R12: configuration readback
        wr(ua(0, 0), 32'h1000);
        wr(ua(0, 1), 32'h10FF);
        wr(ua(0, 2), 32'h3);
        wr(ua(0, 3), 32'h0024);                // clients 2 and 5
        wr(ga(0), 32'hF);
        chk(ua(0, 1), 32'h10FF, "R12");
        chk(ua(0, 3), 32'h0024, "R12");
        chk(ua(0, 7), 32'h0, "R12");

        // R2: one below the window
        txn(32'h0FFF, 4'd2, 1'b0, 8'd4);
        chk(ga(1), 32'h0, "R2");
        // R2 / R4: first address hits and captures
        txn(32'h1000, 4'd2, 1'b0, 8'd4);
        chk(ga(1), 32'h1, "R7");
        chk(ga(2), 32'h1, "R8");
        chk_irq(1'b1, "R8");
        chk(ua(0, 5), 32'h1000, "R4");
        chk(ua(0, 6), 32'h0004_0200, "R4");
        chk(ua(0, 4), 32'h0004, "R4");
        // R5: last address hits, capture frozen, clients accumulate
        txn(32'h10FF, 4'd5, 1'b1, 8'd8);
        chk(ua(0, 5), 32'h1000, "R5");
        chk(ua(0, 6), 32'h0004_0200, "R5");
        chk(ua(0, 4), 32'h0024, "R5");

        // R3: qualifier checks on unit 1
        wr(ua(1, 0), 32'h2000);
        wr(ua(1, 1), 32'h2000);
        wr(ua(1, 2), 32'h2);                   // writes only
        wr(ua(1, 3), 32'h0002);                // client 1 only
        txn(32'h2000, 4'd1, 1'b0, 8'd16);      // read: op not enabled
        chk(ga(1), 32'h1, "R3");
        txn(32'h2000, 4'd3, 1'b1, 8'd16);      // client not selected
        chk(ga(1), 32'h1, "R3");
        txn(32'h2001, 4'd1, 1'b1, 8'd16);      // above window
        chk(ga(1), 32'h1, "R2");
        txn(32'h2000, 4'd1, 1'b1, 8'd16);      // full match
        chk(ga(1), 32'h3, "R3");
        chk(ua(1, 6), 32'h0010_0101, "R4");

        // R8: mask selects sources
        wr(ga(0), 32'h2);
        chk(ga(2), 32'h2, "R8");
        chk_irq(1'b1, "R8");
        wr(ga(0), 32'h1);
        // R7: W1C on bit 0 only
        wr(ga(3), 32'h1);
        chk(ga(1), 32'h2, "R7");
        chk(ga(2), 32'h0, "R8");
        chk_irq(1'b0, "R8");
        chk(ga(3), 32'h0, "R12");

        // R6: unit acknowledge clears capture, status untouched
        wr(ua(0, 7), 32'h0);
        chk(ua(0, 5), 32'h0, "R6");
        chk(ua(0, 4), 32'h0, "R6");
        chk(ua(0, 6), 32'h0, "R6");
        chk(ga(1), 32'h2, "R6");
        txn(32'h1080, 4'd5, 1'b1, 8'd2);
        chk(ua(0, 5), 32'h1080, "R6");
        chk(ua(0, 6), 32'h0002_0501, "R6");
        chk(ua(0, 4), 32'h0020, "R6");
        chk(ga(1), 32'h3, "R7");

        // R9: hit collides with interrupt acknowledge of its bit
        txn_wr(32'h1010, 4'd2, 1'b0, 8'd1, ga(3), 32'h1);
        chk(ga(1), 32'h3, "R9");
        chk(ua(0, 5), 32'h1080, "R5");
        chk(ua(0, 4), 32'h0024, "R5");

        // R10: hit collides with unit acknowledge
        txn_wr(32'h10A0, 4'd2, 1'b0, 8'd1, ua(0, 7), 32'h0);
        chk(ua(0, 5), 32'h10A0, "R10");
        chk(ua(0, 6), 32'h0001_0200, "R10");
        chk(ua(0, 4), 32'h0004, "R10");

        // R11: one transaction hits two units
        wr(ua(2, 0), 32'h3000);
        wr(ua(2, 1), 32'h3FFF);
        wr(ua(2, 2), 32'h3);
        wr(ua(2, 3), 32'hFFFF);
        wr(ua(3, 0), 32'h3000);
        wr(ua(3, 1), 32'h3FFF);
        wr(ua(3, 2), 32'h3);
        wr(ua(3, 3), 32'h8000);
        txn(32'h3ABC, 4'd15, 1'b1, 8'd3);
        chk(ga(1), 32'hF, "R11");
        chk(ua(2, 5), 32'h3ABC, "R11");
        chk(ua(3, 6), 32'h0003_0F01, "R11");
        chk(ua(0, 5), 32'h10A0, "R11");
        wr(ga(3), 32'hF);
        chk(ga(1), 32'h0, "R7");
        chk_irq(1'b0, "R8");

        @(posedge clk); #3;
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_miss);
        $finish;
    end

endmodule